// File: doc/BRIEF.md
# Upper-Memory Shadow Routing Controller

This block holds the configuration that steers three 128 KB upper-memory windows of a PC-style system, based at 0xA0000, 0xC0000 and 0xE0000. For each window it tells the memory path where reads go and where writes go: on-board DRAM or the external expansion bus. It can also block writes to the lowest window. Software sets the routing through two byte-wide registers on a synchronous I/O port bus.

A lock bit closes the block for good. Once it is set, the two ports stop answering and the routing stays fixed until reset. Any write that changes a routing or protect setting raises a single-cycle flush strobe, so that downstream caches or translation buffers can discard stale mappings.

Top module: `upper_mem_router`

## Requirements
- R1: Only I/O addresses 0x22 (low register) and 0x23 (high register) are claimed, and only while `ioRd` or `ioWr` is high. When an access is not claimed, `ioClaim` is low and `ioRdData` reads 0xFF.
- R2: After reset the low register reads 0xD8 and the high register reads 0x00. All `rdInternal`, `wrInternal` and `wrDisable` bits are 0 and `locked` is 0.
- R3: A write to 0x22 stores the written byte ORed with 0xD8, so bits 7, 6, 4 and 3 always read as 1.
- R4: Window 2 (0xE0000) has reads and writes internal (`rdInternal[2]`, `wrInternal[2]` = 1) when bit 0 of the low register is 1, and external otherwise. Its `wrDisable[2]` is always 0.
- R5: Window 1 (0xC0000) has reads and writes internal when bit 1 of the high register is 1, and external otherwise. Its `wrDisable[1]` is always 0.
- R6: Window 0 (0xA0000) reads follow bit 1 of the high register. When bit 3 of the high register is 1, `wrDisable[0]` is 1 and `wrInternal[0]` is 0. Otherwise writes follow bit 1.
- R7: A write to 0x23 with bit 7 set stores the value and sets `locked`. While locked, neither port is claimed, reads give 0xFF, and writes have no effect on any register or output. Only reset clears the lock.
- R8: `flushPulse` is high for exactly the one cycle after the write edge when that write changes bit 0 of the low register or any of bits 3..1 of the high register. It stays low for every other write, including writes that change only other bits.
- R9: Read data for a claimed read is valid combinationally in the same cycle as `ioRd`. It holds the stored register value, and all eight bits of the high register read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 16 | I/O port address |
| ioWrData | input | 8 | Write data |
| ioRd | input | 1 | Read strobe |
| ioWr | input | 1 | Write strobe, sampled at the rising edge |
| ioRdData | output | 8 | Read data, 0xFF when not claimed |
| ioClaim | output | 1 | Block responds to the current access |
| rdInternal | output | 3 | Per window: reads go to on-board DRAM |
| wrInternal | output | 3 | Per window: writes go to on-board DRAM |
| wrDisable | output | 3 | Per window: writes are blocked |
| flushPulse | output | 1 | One-cycle mapping flush strobe |
| locked | output | 1 | Ports are closed until reset |

## Verification
Read data and the claim signal are combinational: they are due in the same cycle as the strobe. The bench samples them 1 ns after driving the strobe, before the next rising edge. Routing outputs and `locked` change at the rising edge that captures a write, and `flushPulse` is high during the cycle that follows that edge. The bench drives each write on a falling edge and samples all of these on the next falling edge. It then samples `flushPulse` once more a cycle later to confirm that the pulse lasts one cycle.

// File: rtl/umr_pkg.sv
package umr_pkg;
  localparam int NUM_WIN = 3;
  localparam int WIN_A = 0;
  localparam int WIN_C = 1;
  localparam int WIN_E = 2;

  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic rdLo;
    logic rdHi;
  } portStrobes_t;
endpackage

// File: rtl/umr_decode.sv
module umr_decode
  import umr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LO_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] HI_PORT = 16'h0023
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic              locked,
  output portStrobes_t      stb,
  output logic              ioClaim
);
  logic hitLo, hitHi;

  always_comb begin
    hitLo   = (ioAddr == LO_PORT);
    hitHi   = (ioAddr == HI_PORT);
    ioClaim = !locked && (hitLo || hitHi) && (ioRd || ioWr);
    stb.wrLo = ioClaim && hitLo && ioWr;
    stb.wrHi = ioClaim && hitHi && ioWr;
    stb.rdLo = ioClaim && hitLo && ioRd;
    stb.rdHi = ioClaim && hitHi && ioRd;
  end
endmodule

// File: rtl/umr_regs.sv
module umr_regs
  import umr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] LO_FIXED = 8'hD8,
  parameter int ROUTE_E_BIT = 0,
  parameter logic [DATA_W-1:0] HI_FLUSH_MASK = 8'h0E,
  parameter int LOCK_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobes_t      stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] regLo,
  output logic [DATA_W-1:0] regHi,
  output logic              locked,
  output logic              flushPulse
);
  logic loChange, hiChange;

  always_comb begin
    loChange = (wrData[ROUTE_E_BIT] != regLo[ROUTE_E_BIT]);
    hiChange = |((wrData ^ regHi) & HI_FLUSH_MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regLo      <= LO_FIXED;
      regHi      <= '0;
      locked     <= 1'b0;
      flushPulse <= 1'b0;
    end else begin
      flushPulse <= 1'b0;
      if (stb.wrLo) begin
        regLo      <= wrData | LO_FIXED;
        flushPulse <= loChange;
      end
      if (stb.wrHi) begin
        regHi      <= wrData;
        flushPulse <= hiChange;
        if (wrData[LOCK_BIT]) locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/umr_winmap.sv
module umr_winmap
  import umr_pkg::*;
(
  input  logic [NUM_WIN-1:0] routeSel,
  input  logic [NUM_WIN-1:0] protect,
  output logic [NUM_WIN-1:0] rdInternal,
  output logic [NUM_WIN-1:0] wrInternal,
  output logic [NUM_WIN-1:0] wrDisable
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_comb begin
      rdInternal[w] = routeSel[w];
      wrDisable[w]  = protect[w];
      wrInternal[w] = routeSel[w] && !protect[w];
    end
  end
endmodule

// File: rtl/upper_mem_router.sv
module upper_mem_router
  import umr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] LO_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] HI_PORT = 16'h0023,
  parameter logic [DATA_W-1:0] LO_FIXED = 8'hD8,
  parameter int ROUTE_E_BIT = 0,
  parameter int ROUTE_AC_BIT = 1,
  parameter int PROT_A_BIT = 3,
  parameter int LOCK_BIT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  ioAddr,
  input  logic [DATA_W-1:0]  ioWrData,
  input  logic               ioRd,
  input  logic               ioWr,
  output logic [DATA_W-1:0]  ioRdData,
  output logic               ioClaim,
  output logic [NUM_WIN-1:0] rdInternal,
  output logic [NUM_WIN-1:0] wrInternal,
  output logic [NUM_WIN-1:0] wrDisable,
  output logic               flushPulse,
  output logic               locked
);
  localparam logic [DATA_W-1:0] HI_FLUSH_MASK =
    DATA_W'((1 << ROUTE_AC_BIT) | (1 << 2) | (1 << PROT_A_BIT));

  portStrobes_t stb;
  logic [DATA_W-1:0] regLo, regHi;
  logic [NUM_WIN-1:0] routeSel, protect;

  umr_decode #(.ADDR_W(ADDR_W), .LO_PORT(LO_PORT), .HI_PORT(HI_PORT)) u_decode (
    .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr), .locked(locked),
    .stb(stb), .ioClaim(ioClaim)
  );

  umr_regs #(
    .DATA_W(DATA_W), .LO_FIXED(LO_FIXED), .ROUTE_E_BIT(ROUTE_E_BIT),
    .HI_FLUSH_MASK(HI_FLUSH_MASK), .LOCK_BIT(LOCK_BIT)
  ) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(ioWrData),
    .regLo(regLo), .regHi(regHi), .locked(locked), .flushPulse(flushPulse)
  );

  always_comb begin
    routeSel        = '0;
    protect         = '0;
    routeSel[WIN_E] = regLo[ROUTE_E_BIT];
    routeSel[WIN_C] = regHi[ROUTE_AC_BIT];
    routeSel[WIN_A] = regHi[ROUTE_AC_BIT];
    protect[WIN_A]  = regHi[PROT_A_BIT];
    if (stb.rdLo)      ioRdData = regLo;
    else if (stb.rdHi) ioRdData = regHi;
    else               ioRdData = '1;
  end

  umr_winmap u_winmap (
    .routeSel(routeSel), .protect(protect),
    .rdInternal(rdInternal), .wrInternal(wrInternal), .wrDisable(wrDisable)
  );
endmodule

// File: rtl/upper_mem_router_chk.sv
module upper_mem_router_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NWIN = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioRd,
  input logic              ioWr,
  input logic [DATA_W-1:0] ioRdData,
  input logic              ioClaim,
  input logic [NWIN-1:0]   rdInternal,
  input logic [NWIN-1:0]   wrInternal,
  input logic [NWIN-1:0]   wrDisable,
  input logic              flushPulse,
  input logic              locked
);
  p_claim_needs_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    ioClaim |-> (ioRd || ioWr));
  p_claim_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    ioClaim |-> (ioAddr == ADDR_W'(16'h22) || ioAddr == ADDR_W'(16'h23)));
  p_idle_ff_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ioClaim |-> (ioRdData == '1));
  p_fixed_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ioClaim && ioRd && ioAddr == ADDR_W'(16'h22)) |-> ((ioRdData & 8'hD8) == 8'hD8));
  p_prot_blocks_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrDisable[0] |-> !wrInternal[0]);
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);
  p_lock_no_claim_r7: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !ioClaim);
  p_lock_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> ($stable(rdInternal) && $stable(wrInternal) && $stable(wrDisable)));
  p_flush_after_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |-> $past(ioWr && ioClaim));
  p_route_change_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(rdInternal) && !$rose(locked)) |-> flushPulse);
endmodule

bind upper_mem_router upper_mem_router_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWIN(umr_pkg::NUM_WIN)) chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
  .ioRdData(ioRdData), .ioClaim(ioClaim), .rdInternal(rdInternal),
  .wrInternal(wrInternal), .wrDisable(wrDisable), .flushPulse(flushPulse),
  .locked(locked)
);

// File: tb/upper_mem_router_test.sv
module upper_mem_router_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0] ioWrData = '0;
  logic ioRd = 1'b0, ioWr = 1'b0;
  logic [7:0] ioRdData;
  logic ioClaim, flushPulse, locked;
  logic [2:0] rdInternal, wrInternal, wrDisable;
  int nRun = 0, nFail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  upper_mem_router uut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioRd(ioRd), .ioWr(ioWr), .ioRdData(ioRdData), .ioClaim(ioClaim),
    .rdInternal(rdInternal), .wrInternal(wrInternal), .wrDisable(wrDisable),
    .flushPulse(flushPulse), .locked(locked)
  );

  // {addr, data, expLo, expHi, rd[2:0], wr[2:0], dis[2:0], flush}; bit2=E, bit1=C, bit0=A
  localparam logic [41:0] VEC [10] = '{
    {8'h22, 8'h01, 8'hD9, 8'h00, 3'b100, 3'b100, 3'b000, 1'b1},
    {8'h22, 8'h01, 8'hD9, 8'h00, 3'b100, 3'b100, 3'b000, 1'b0},
    {8'h22, 8'h24, 8'hFC, 8'h00, 3'b000, 3'b000, 3'b000, 1'b1},
    {8'h23, 8'h02, 8'hFC, 8'h02, 3'b011, 3'b011, 3'b000, 1'b1},
    {8'h23, 8'h0A, 8'hFC, 8'h0A, 3'b011, 3'b010, 3'b001, 1'b1},
    {8'h23, 8'h0E, 8'hFC, 8'h0E, 3'b011, 3'b010, 3'b001, 1'b1},
    {8'h23, 8'h4E, 8'hFC, 8'h4E, 3'b011, 3'b010, 3'b001, 1'b0},
    {8'h23, 8'h08, 8'hFC, 8'h08, 3'b000, 3'b000, 3'b001, 1'b1},
    {8'h22, 8'h00, 8'hD8, 8'h08, 3'b000, 3'b000, 3'b001, 1'b0},
    {8'h23, 8'h00, 8'hD8, 8'h00, 3'b000, 3'b000, 3'b000, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic doRead(input logic [15:0] a, output logic [7:0] d, output logic c);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    #1;
    d = ioRdData; c = ioClaim;
    ioRd = 1'b0;
  endtask

  task automatic checkOuts(input string req, input logic [2:0] r, input logic [2:0] w, input logic [2:0] x);
    check({req, " rdInternal"}, {5'd0, rdInternal}, {5'd0, r});
    check({req, " wrInternal"}, {5'd0, wrInternal}, {5'd0, w});
    check({req, " wrDisable"}, {5'd0, wrDisable}, {5'd0, x});
  endtask

  initial begin
    #400000;
    if (!done) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic cl;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2 reset state
    doRead(16'h22, rd, cl);
    check("R2 low reset", rd, 8'hD8);
    doRead(16'h23, rd, cl);
    check("R2 high reset", rd, 8'h00);
    checkOuts("R2", 3'b000, 3'b000, 3'b000);
    check("R2 locked", {7'd0, locked}, 8'h00);
    // R1 decode
    doRead(16'h24, rd, cl);
    check("R1 unclaimed read data", rd, 8'hFF);
    check("R1 unclaimed claim", {7'd0, cl}, 8'h00);
    @(negedge clk); ioAddr = 16'h22; #1;
    check("R1 no strobe claim", {7'd0, ioClaim}, 8'h00);
    doWrite(16'h0021, 8'hFF);
    doWrite(16'h0123, 8'hFF);
    checkOuts("R1 foreign write", 3'b000, 3'b000, 3'b000);
    doRead(16'h23, rd, cl);
    check("R1 foreign write ignored", rd, 8'h00);
    check("R1 claim on own port", {7'd0, cl}, 8'h01);

    // R3..R6, R8, R9 vector walk
    for (int i = 0; i < 10; i++) begin
      doWrite({8'h00, VEC[i][41:34]}, VEC[i][33:26]);
      check("R8 flush after write", {7'd0, flushPulse}, {7'd0, VEC[i][0]});
      checkOuts("R4 R5 R6 routing", VEC[i][9:7], VEC[i][6:4], VEC[i][3:1]);
      doRead(16'h22, rd, cl);
      check("R3 R9 low readback", rd, VEC[i][25:18]);
      doRead(16'h23, rd, cl);
      check("R9 high readback", rd, VEC[i][17:10]);
    end

    // R8 pulse length
    doWrite(16'h22, 8'hFF);
    check("R8 pulse high", {7'd0, flushPulse}, 8'h01);
    @(negedge clk);
    check("R8 pulse one cycle", {7'd0, flushPulse}, 8'h00);
    checkOuts("R4 window E internal", 3'b100, 3'b100, 3'b000);

    // R7 lock
    doWrite(16'h23, 8'h82);
    check("R7 lock set", {7'd0, locked}, 8'h01);
    check("R8 flush on lock write", {7'd0, flushPulse}, 8'h01);
    checkOuts("R7 lock write routing", 3'b111, 3'b111, 3'b000);
    doRead(16'h23, rd, cl);
    check("R7 locked read data", rd, 8'hFF);
    check("R7 locked claim", {7'd0, cl}, 8'h00);
    doWrite(16'h22, 8'h00);
    check("R7 locked no flush", {7'd0, flushPulse}, 8'h00);
    doWrite(16'h23, 8'h08);
    checkOuts("R7 locked writes ignored", 3'b111, 3'b111, 3'b000);
    check("R7 lock sticky", {7'd0, locked}, 8'h01);

    // R2 reset clears the lock
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R2 lock cleared by reset", {7'd0, locked}, 8'h00);
    doRead(16'h22, rd, cl);
    check("R2 low after reset", rd, 8'hD8);
    checkOuts("R2 after reset", 3'b000, 3'b000, 3'b000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule